// File: doc/BRIEF.md
# Programmable SDRAM Window Address Router

This block sits behind a processor's address output and picks, for every request, one of two downstream masters. Two software-written boundary registers mark out a window on 1 MB granularity. A request whose address falls inside the window goes to the SDRAM master. A request outside the window goes to the system interconnect master. In both cases the address passes through untouched, with no offset added or removed.

The SDRAM sees the same address the processor issued. With the reset window starting at 1 MB, the bottom megabyte of SDRAM is therefore hidden. That same megabyte, reached through the interconnect, is the boot region. A remap control bit chooses whether the boot region is served by on-chip RAM or by boot ROM. Software lowers the start boundary to zero to expose the bottom SDRAM megabyte. It moves the boundary back to keep the boot region reachable.

The request path is a two-state machine. In state `S_IDLE` no result is presented. In state `S_ISSUE` a registered route result is on the outputs. Transition `T_ACCEPT` (either state, `req_valid` high) enters or stays in `S_ISSUE`. Transition `T_DRAIN` (either state, `req_valid` low) enters or stays in `S_IDLE`. Each accepted request therefore yields exactly one result on the following cycle.

Top module: `sdram_win_router`

## Requirements
- R1: After reset, register offset 0 (window start) reads 0x00100000, offset 1 (window end) reads 0xC0000000, and offset 2 (remap control, bit 0) reads 0. Offset 3 reads 0, and writes to offset 3 change nothing.
- R2: Writes to offsets 0 and 1 keep only bits 31:20, and bits 19:0 read back as 0. A write to offset 2 keeps only bit 0, and bits 31:1 read back as 0.
- R3: A request whose address satisfies start <= addr < end, comparing bits 31:20 only, produces `rsp_route` = 2'b01 (the SDRAM master).
- R4: Any other address produces `rsp_route` = 2'b10 (the interconnect master). When end <= start, every address goes to the interconnect.
- R5: `rsp_valid` is high on exactly the cycle after each cycle with `req_valid` high. In that cycle `rsp_addr` equals the request address.
- R6: A register write in cycle N applies to requests accepted in cycle N+1 onward. A request accepted in cycle N is decoded with the old register values.
- R7: `rsp_boot` is 1 exactly when the request was routed to the interconnect and the address bits 31:20 are 0, which marks the 1 MB boot region at address 0.
- R8: `boot_ram_sel` follows remap bit 0 on the cycle after the write. A value of 1 selects on-chip RAM and 0 selects boot ROM. The reset value is 0 (boot ROM).
- R9: With start programmed to 0, addresses in the bottom megabyte route to SDRAM, and `rsp_boot` stays 0 for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 start, 1 end, 2 remap |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Route result present |
| rsp_route | output | 2 | One-hot target: bit 0 SDRAM, bit 1 interconnect |
| rsp_addr | output | 32 | Address passed on unchanged |
| rsp_boot | output | 1 | Request hit the boot region through the interconnect |
| boot_ram_sel | output | 1 | Boot target: 1 on-chip RAM, 0 boot ROM |

## Verification
The bench builds the router with its default parameters. These are a 32-bit address, a 20-bit (1 MB) granule, the 1 MB and 3 GB reset boundaries, and a one-page boot region. The real 4 GB map, the default hole at the bottom SDRAM megabyte and the boot-region overlap are therefore all reachable. The bench probes start-1, start, end-1 and end under the reset window, under reprogrammed windows, under the start = 0 window and under an inverted window. It covers both remap settings, and it issues a write and a request in the same cycle to pin down the ordering.

// File: rtl/sdram_win_router_pkg.sv
package sdram_win_router_pkg;
    typedef enum logic {S_IDLE, S_ISSUE} rt_state_e;

    localparam logic [1:0] ROUTE_SDRAM = 2'b01;
    localparam logic [1:0] ROUTE_ICONN = 2'b10;

    localparam logic [1:0] OFS_START = 2'd0;
    localparam logic [1:0] OFS_END   = 2'd1;
    localparam logic [1:0] OFS_REMAP = 2'd2;
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import sdram_win_router_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 20,
    parameter logic [ADDR_W-1:0] START_RST = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] END_RST   = 32'hC000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [ADDR_W-1:0]    wdata,
    output logic [ADDR_W-1:0]    rdata,
    output logic [ADDR_W-GRAN_W-1:0] start_page,
    output logic [ADDR_W-GRAN_W-1:0] end_page,
    output logic                 remap
);
    localparam int PAGE_W = ADDR_W - GRAN_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK  = {{PAGE_W{1'b1}}, {GRAN_W{1'b0}}};
    localparam logic [ADDR_W-1:0] REMAP_MASK = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] start_q, end_q, remap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= START_RST & PAGE_MASK;
            end_q   <= END_RST & PAGE_MASK;
            remap_q <= '0;
        end else if (we) begin
            unique case (addr)
                OFS_START: start_q <= wdata & PAGE_MASK;
                OFS_END:   end_q   <= wdata & PAGE_MASK;
                OFS_REMAP: remap_q <= wdata & REMAP_MASK;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            OFS_START: rdata = start_q;
            OFS_END:   rdata = end_q;
            OFS_REMAP: rdata = remap_q;
            default:   rdata = '0;
        endcase
    end

    assign start_page = start_q[ADDR_W-1:GRAN_W];
    assign end_page   = end_q[ADDR_W-1:GRAN_W];
    assign remap      = remap_q[0];
endmodule

// File: rtl/win_decode.sv
module win_decode
    import sdram_win_router_pkg::*;
#(
    parameter int PAGE_W     = 12,
    parameter int BOOT_PAGES = 1
) (
    input  logic [PAGE_W-1:0] addr_page,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [PAGE_W-1:0] end_page,
    output logic [1:0]        route,
    output logic              boot_hit
);
    localparam logic [PAGE_W-1:0] BOOT_LIM = PAGE_W'(BOOT_PAGES);

    logic in_win;

    always_comb begin
        in_win   = (addr_page >= start_page) && (addr_page < end_page);
        route    = in_win ? ROUTE_SDRAM : ROUTE_ICONN;
        boot_hit = !in_win && (addr_page < BOOT_LIM);
    end
endmodule

// File: rtl/sdram_win_router.sv
module sdram_win_router
    import sdram_win_router_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 20,
    parameter int BOOT_PAGES = 1,
    parameter logic [ADDR_W-1:0] START_RST = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] END_RST   = 32'hC000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_boot,
    output logic              boot_ram_sel
);
    localparam int PAGE_W = ADDR_W - GRAN_W;

    logic [PAGE_W-1:0] start_page, end_page;
    logic              remap;
    logic [1:0]        dec_route;
    logic              dec_boot;

    win_cfg_regs #(
        .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
        .START_RST(START_RST), .END_RST(END_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .start_page(start_page), .end_page(end_page), .remap(remap)
    );

    win_decode #(.PAGE_W(PAGE_W), .BOOT_PAGES(BOOT_PAGES)) dec_i (
        .addr_page(req_addr[ADDR_W-1:GRAN_W]),
        .start_page(start_page), .end_page(end_page),
        .route(dec_route), .boot_hit(dec_boot)
    );

    rt_state_e state_q, state_d;
    logic [1:0]        route_q;
    logic [ADDR_W-1:0] addr_q;
    logic              boot_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_ISSUE : S_IDLE;
            S_ISSUE: state_d = req_valid ? S_ISSUE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= ROUTE_ICONN;
            addr_q  <= '0;
            boot_q  <= 1'b0;
        end else if (req_valid) begin
            route_q <= dec_route;
            addr_q  <= req_addr;
            boot_q  <= dec_boot;
        end
    end

    // outputs
    always_comb begin
        rsp_valid    = (state_q == S_ISSUE);
        rsp_route    = rsp_valid ? route_q : 2'b00;
        rsp_addr     = addr_q;
        rsp_boot     = rsp_valid && boot_q;
        boot_ram_sel = remap;
    end
endmodule

// File: rtl/sdram_win_router_chk.sv
module sdram_win_router_chk #(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [1:0]        rsp_route,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_boot,
    input logic              boot_ram_sel
);
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r5_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr == $past(req_addr)));
    a_r3_onehot_route: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_route) == 1));
    a_r7_boot_iconn: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_boot |-> (rsp_route == 2'b10 && rsp_addr[ADDR_W-1:GRAN_W] == '0));
    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 2'd2) |-> (reg_rdata[GRAN_W-1:0] == '0));
    a_r8_remap_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd2) |=> (boot_ram_sel == $past(reg_wdata[0])));
endmodule

bind sdram_win_router sdram_win_router_chk #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
    .rsp_addr(rsp_addr), .rsp_boot(rsp_boot), .boot_ram_sel(boot_ram_sel)
);

// File: tb/sdram_win_router_tb_top.sv
module sdram_win_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_addr;
    logic        rsp_boot;
    logic        boot_ram_sel;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_start = 32'h0010_0000;
    logic [31:0] m_end   = 32'hC000_0000;
    logic        m_remap = 1'b0;

    always #10 clk = ~clk;

    sdram_win_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_addr(rsp_addr), .rsp_boot(rsp_boot), .boot_ram_sel(boot_ram_sel)
    );

    function automatic logic [1:0] exp_route(input logic [31:0] a);
        if (a[31:20] >= m_start[31:20] && a[31:20] < m_end[31:20]) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic exp_boot(input logic [31:0] a);
        return (exp_route(a) == 2'b10) && (a[31:20] == 12'd0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ofs; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (ofs)
            2'd0: m_start = d & 32'hFFF0_0000;
            2'd1: m_end   = d & 32'hFFF0_0000;
            2'd2: m_remap = d[0];
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [1:0] ofs, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = ofs;
        #1 check(req, reg_rdata, exp);
    endtask

    // one request; result sampled at the following falling edge
    task automatic probe(input string req, input logic [31:0] a);
        logic [1:0] er;
        logic eb;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        er = exp_route(a); eb = exp_boot(a);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " route"}, {30'd0, rsp_route}, {30'd0, er});
        check({"R5 addr ", req}, rsp_addr, a);
        check({"R7 boot ", req}, {31'd0, rsp_boot}, {31'd0, eb});
    endtask

    task automatic edges(input string req);
        probe(req, m_start - 32'd1);
        probe(req, m_start);
        probe(req, m_end - 32'd1);
        probe(req, m_end);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R5 reset idle", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        rd("R1 start", 2'd0, 32'h0010_0000);
        rd("R1 end", 2'd1, 32'hC000_0000);
        rd("R1 remap", 2'd2, 32'd0);
        check("R8 reset rom", {31'd0, boot_ram_sel}, 32'd0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd("R1 ofs3", 2'd3, 32'd0);
        rd("R1 ofs3 no effect", 2'd0, 32'h0010_0000);

        edges("R3 R4 reset window");
        probe("R4 R7 boot region", 32'h0000_1234);
        probe("R4 top", 32'hFFFF_FFFF);

        // idle cycle yields no result
        @(negedge clk);
        check("R5 idle", {31'd0, rsp_valid}, 32'd0);

        wr(2'd0, 32'h2345_6789);
        rd("R2 start low", 2'd0, 32'h2340_0000);
        wr(2'd1, 32'h8000_FFFF);
        rd("R2 end low", 2'd1, 32'h8000_0000);
        wr(2'd2, 32'hFFFF_FFFF);
        rd("R2 remap bits", 2'd2, 32'd1);
        check("R8 ram", {31'd0, boot_ram_sel}, 32'd1);
        edges("R3 R4 moved window");
        wr(2'd2, 32'h0);
        check("R8 rom", {31'd0, boot_ram_sel}, 32'd0);

        wr(2'd0, 32'h0);
        probe("R9 low mb sdram", 32'h0000_0010);
        probe("R9 low mb top", 32'h000F_FFFF);
        edges("R9 R3 start zero");

        wr(2'd0, 32'h9000_0000);
        wr(2'd1, 32'h9000_0000);
        probe("R4 empty window", 32'h9000_0000);
        wr(2'd1, 32'h1000_0000);
        probe("R4 inverted window", 32'h2000_0000);
        probe("R4 inverted low", 32'h0000_0000);

        // R6: write and request in the same cycle use the old window
        wr(2'd0, 32'h0010_0000);
        wr(2'd1, 32'hC000_0000);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h4000_0000;
        req_valid = 1'b1; req_addr = 32'h2000_0000;
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0;
        check("R6 same cycle old", {30'd0, rsp_route}, 32'd1);
        m_start = 32'h4000_0000;
        probe("R6 next cycle new", 32'h2000_0000);

        // random windows and addresses
        for (int i = 0; i < 200; i++) begin
            if (i % 20 == 0) begin
                wr(2'd0, $urandom);
                wr(2'd1, $urandom);
                wr(2'd2, $urandom);
                check("R8 random", {31'd0, boot_ram_sel}, {31'd0, m_remap});
            end
            if (i % 4 == 0) probe("R3 R4 random", $urandom);
            else if (i % 4 == 1) probe("R3 R4 random start", m_start + ($urandom % 32'h0020_0000) - 32'h0010_0000);
            else if (i % 4 == 2) probe("R3 R4 random end", m_end + ($urandom % 32'h0020_0000) - 32'h0010_0000);
            else probe("R7 random low", $urandom % 32'h0020_0000);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule